// File: doc/BRIEF.md
# USB Device Interrupt Flag Register

This block holds the interrupt flags of a USB device controller in one 8-bit register that a CPU can read and write. The protocol engine raises single-cycle event pulses when the endpoint information load finishes, when a start-of-frame arrives, and when a Set_Configuration or Set_Interface request is seen. Each pulse sets its own flag. The engine also drives a bus suspend level. The block shows that level as a live status bit and raises a separate flag each time the level changes in either direction.

Software clears a flag by writing 0 to its bit and 1 to every other bit, so clearing one flag cannot disturb the others. The start-of-frame flag is the exception: writes cannot touch it, and a read strobe on the flag register clears it. A second 8-bit register holds the interrupt enables. The interrupt output is registered. It is high when at least one flag is set together with its enable bit. The suspend status bit never takes part in the interrupt.

The register port is flat. `reg_sel` picks the register: 0 is the flag register and 1 is the enable register. `reg_wr` and `reg_rd` are single-cycle strobes. `reg_rdata` shows the selected register at all times, within the same cycle. Event pulses and writes act at the next rising clock edge.

Top module: `usbd_irq_flags`

## Requirements
- R1: After reset, the flag register reads 0x00, the enable register reads 0x00, and `irq` is 0.
- R2: Bits 7 and 6 of the flag register always read 0, and writes to them have no effect.
- R3: Bit 5 of the flag register shows `bus_suspend` one clock edge after it is sampled (0 means normal, 1 means suspended). Bit 5 never asserts `irq`, even when enable bit 5 is 1.
- R4: Bit 4 is set at the clock edge where a `bus_suspend` change is first sampled. This applies to the change from 0 to 1 and to the change from 1 to 0.
- R5: `ev_epinfo_done` sets bit 3, `ev_set_cfg` sets bit 1 and `ev_set_intf` sets bit 0, at the edge where the pulse is sampled.
- R6: `ev_sof` sets bit 2. CPU writes never change bit 2. A `reg_rd` strobe with `reg_sel`=0 clears bit 2, unless `ev_sof` is high in the same cycle, in which case bit 2 stays 1.
- R7: A write with `reg_sel`=0 clears each of bits 4, 3, 1 and 0 whose write-data bit is 0. A write-data bit of 1 leaves its flag unchanged.
- R8: When a set event and a write-0 clear hit the same flag in the same cycle, the flag ends up 1.
- R9: The enable register is a plain 8-bit read/write register at `reg_sel`=1. A write takes effect at the next edge.
- R10: `irq` is updated one edge after the flags and enables. It is 1 exactly when (flags[4:0] AND enable[4:0]) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| bus_suspend | input | 1 | Bus suspend level from the protocol engine |
| ev_epinfo_done | input | 1 | Pulse: endpoint information load finished |
| ev_sof | input | 1 | Pulse: start-of-frame detected |
| ev_set_cfg | input | 1 | Pulse: Set_Configuration request detected |
| ev_set_intf | input | 1 | Pulse: Set_Interface request detected |
| reg_sel | input | 1 | Register select: 0 flags, 1 enables |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect: clears the start-of-frame flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
Event pulses, writes and read strobes act at the edge that samples them. The flag register shows the result right after that edge, and the suspend status and suspend change flag show their result after the same edge. `irq` trails the flags and enables by one more edge. The bench therefore drives every input just after a falling edge and clocks one rising edge. It reads `reg_rdata` on the next falling edge, and for `irq` it checks once at that falling edge, where the old value is still expected, and again one cycle later, where the new value is due. Flag values are peeked with `reg_rd` low, so the peek itself does not clear the start-of-frame flag.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;
  localparam int DW        = 8;
  localparam int NFLAG     = 5;
  // bit positions inside the flag register
  localparam int B_SINTF   = 0;
  localparam int B_SCFG    = 1;
  localparam int B_SOF     = 2;
  localparam int B_EPLD    = 3;
  localparam int B_SCHG    = 4;
  localparam int B_SSTAT   = 5;
  // per-flag behaviour masks (bit i refers to flag i)
  localparam logic [NFLAG-1:0] CPU_CLR_MASK = 5'b11011;
  localparam logic [NFLAG-1:0] RD_CLR_MASK  = 5'b00100;

  typedef enum logic {
    SEL_FLAGS  = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/usbd_flag_cell.sv
module usbd_flag_cell #(
  parameter bit CPU_CLR = 1'b1,
  parameter bit RD_CLR  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic rd_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic load;
  logic clr;

  always_comb begin
    clr    = (CPU_CLR && wr_i && !wbit_i) || (RD_CLR && rd_i);
    load   = set_i || clr;
    // a set in the same cycle as a clear keeps the event
    flag_d = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (load) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/usbd_susp_track.sv
module usbd_susp_track (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic level_o,
  output logic change_o
);
  logic lvl_q;
  logic lvl_d;
  logic upd;

  always_comb begin
    change_o = level_i ^ lvl_q;
    upd      = change_o;
    lvl_d    = level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (upd) begin
      lvl_q <= lvl_d;
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/usbd_irq_merge.sv
module usbd_irq_merge #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(flags_i & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/usbd_irq_flags.sv
module usbd_irq_flags
  import usbd_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_suspend,
  input  logic          ev_epinfo_done,
  input  logic          ev_sof,
  input  logic          ev_set_cfg,
  input  logic          ev_set_intf,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam int RSVD_W = DW - NFLAG - 1;

  reg_sel_e         sel;
  logic             wr_flags;
  logic             rd_flags;
  logic             wr_en;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] flag_q;
  logic             susp_q;
  logic             susp_chg;
  logic [DW-1:0]    en_q;
  logic [DW-1:0]    en_d;

  always_comb begin
    sel      = reg_sel_e'(reg_sel);
    wr_flags = reg_wr && (sel == SEL_FLAGS);
    rd_flags = reg_rd && (sel == SEL_FLAGS);
    wr_en    = reg_wr && (sel == SEL_ENABLE);
  end

  usbd_susp_track u_susp (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (bus_suspend),
    .level_o  (susp_q),
    .change_o (susp_chg)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[B_SINTF] = ev_set_intf;
    set_vec[B_SCFG]  = ev_set_cfg;
    set_vec[B_SOF]   = ev_sof;
    set_vec[B_EPLD]  = ev_epinfo_done;
    set_vec[B_SCHG]  = susp_chg;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    usbd_flag_cell #(
      .CPU_CLR (CPU_CLR_MASK[i]),
      .RD_CLR  (RD_CLR_MASK[i])
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[i]),
      .wr_i   (wr_flags),
      .wbit_i (reg_wdata[i]),
      .rd_i   (rd_flags),
      .flag_o (flag_q[i])
    );
  end

  // enable register
  always_comb begin
    en_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q <= en_d;
    end
  end

  usbd_irq_merge #(.N(NFLAG)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flag_q),
    .en_i    (en_q[NFLAG-1:0]),
    .irq_o   (irq)
  );

  // read path
  always_comb begin
    if (sel == SEL_FLAGS) begin
      reg_rdata = {{RSVD_W{1'b0}}, susp_q, flag_q};
    end else begin
      reg_rdata = en_q;
    end
  end
endmodule

// File: rtl/usbd_irq_flags_chk.sv
module usbd_irq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_suspend,
  input logic       ev_sof,
  input logic       ev_set_cfg,
  input logic       reg_sel,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [4:0] flags,
  input logic       susp_lvl,
  input logic [7:0] en,
  input logic       irq
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 1'b0) |-> (reg_rdata[7:6] == 2'b00));

  p_susp_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (susp_lvl == $past(bus_suspend)));

  p_susp_noirq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past((flags & en[4:0]) == 5'b0)) |-> !irq);

  p_chg_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_suspend != susp_lvl) |=> flags[4]);

  p_sof_cpu_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_sel == 1'b0) && !reg_rd && !ev_sof) |=> (flags[2] == $past(flags[2])));

  p_w1_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_sel == 1'b0) && reg_wdata[0] && flags[0]) |=> flags[0]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set_cfg |=> flags[1]);

  p_en_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_sel == 1'b1)) |=> (en == $past(reg_wdata)));

  p_irq_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq == $past(|(flags & en[4:0]))));
endmodule

bind usbd_irq_flags usbd_irq_flags_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_suspend (bus_suspend),
  .ev_sof      (ev_sof),
  .ev_set_cfg  (ev_set_cfg),
  .reg_sel     (reg_sel),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .flags       (flag_q),
  .susp_lvl    (susp_q),
  .en          (en_q),
  .irq         (irq)
);

// File: tb/sim_usbd_irq_flags.sv
`timescale 1ns/1ps
module sim_usbd_irq_flags;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_suspend, ev_epinfo_done, ev_sof, ev_set_cfg, ev_set_intf;
  logic       reg_sel, reg_wr, reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  usbd_irq_flags u0 (
    .clk(clk), .rst_n(rst_n), .bus_suspend(bus_suspend),
    .ev_epinfo_done(ev_epinfo_done), .ev_sof(ev_sof),
    .ev_set_cfg(ev_set_cfg), .ev_set_intf(ev_set_intf),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {ev(epinfo,sof,cfg,intf)[20:17], wr[16], wdata[15:8], expected flags[7:0]}
  localparam logic [20:0] VEC [10] = '{
    {4'b0010, 1'b0, 8'h00, 8'h02},  // R5 cfg
    {4'b0001, 1'b0, 8'h00, 8'h03},  // R5 intf
    {4'b1000, 1'b0, 8'h00, 8'h0B},  // R5 epinfo
    {4'b0100, 1'b0, 8'h00, 8'h0F},  // R6 sof
    {4'b0000, 1'b1, 8'hFD, 8'h0D},  // R7 clear bit1
    {4'b0000, 1'b1, 8'hFB, 8'h0D},  // R6 write cannot clear sof
    {4'b0000, 1'b1, 8'h00, 8'h04},  // R7 R2 write zero everywhere
    {4'b0010, 1'b1, 8'hFD, 8'h06},  // R8 set beats clear
    {4'b0000, 1'b1, 8'hFF, 8'h06},  // R7 ones keep
    {4'b1001, 1'b0, 8'h00, 8'h0F}   // R5 two events at once
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ev_epinfo_done = 1'b0; ev_sof = 1'b0; ev_set_cfg = 1'b0; ev_set_intf = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    tick();
    idle();
  endtask

  task automatic peek(input logic sel, input string req, input logic [7:0] exp);
    reg_sel = sel; reg_rd = 1'b0;
    #1;
    chk(req, reg_rdata, exp);
    reg_sel = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_suspend = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(1'b0, "R1 flags", 8'h00);
    peek(1'b1, "R1 enable", 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // table walk
    for (int i = 0; i < 10; i++) begin
      {ev_epinfo_done, ev_sof, ev_set_cfg, ev_set_intf} = VEC[i][20:17];
      reg_wr = VEC[i][16]; reg_wdata = VEC[i][15:8]; reg_sel = 1'b0;
      tick();
      idle();
      peek(1'b0, $sformatf("R5/R6/R7/R8 vector %0d", i), VEC[i][7:0]);
    end

    // R6 read strobe clears sof
    reg_sel = 1'b0; reg_rd = 1'b1;
    tick(); idle();
    peek(1'b0, "R6 read clears sof", 8'h0B);
    ev_sof = 1'b1;
    tick(); idle();
    ev_sof = 1'b1; reg_rd = 1'b1; reg_sel = 1'b0;
    tick(); idle();
    peek(1'b0, "R6 event beats read", 8'h0F);
    reg_rd = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00; reg_sel = 1'b0;
    tick(); idle();
    peek(1'b0, "R7 R6 clear all", 8'h00);

    // R3 R4 suspend status and change flag
    wr_reg(1'b1, 8'hE0);
    bus_suspend = 1'b1;
    tick();
    peek(1'b0, "R4 R3 enter suspend", 8'h30);
    wr_reg(1'b0, 8'hEF);
    peek(1'b0, "R7 clear change keep status", 8'h20);
    tick(); tick();
    chk("R3 status never interrupts", {7'b0, irq}, 8'h00);
    bus_suspend = 1'b0;
    tick();
    peek(1'b0, "R4 resume direction", 8'h10);

    // R10 irq latency
    wr_reg(1'b1, 8'h10);
    chk("R10 irq not yet", {7'b0, irq}, 8'h00);
    tick();
    chk("R10 irq asserted", {7'b0, irq}, 8'h01);
    wr_reg(1'b0, 8'hEF);
    chk("R10 irq lags clear", {7'b0, irq}, 8'h01);
    tick();
    chk("R10 irq deasserted", {7'b0, irq}, 8'h00);

    // R9 enable readback, R2 reserved bits
    wr_reg(1'b1, 8'hA5);
    peek(1'b1, "R9 enable readback", 8'hA5);
    wr_reg(1'b0, 8'hFF);
    peek(1'b0, "R2 reserved read zero", 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule